// File: doc/BRIEF.md
# Proximity Output Pin and Interrupt Controller

This block produces the single digital output pin of a proximity sensor from the current proximity decision. It offers two output modes. In level mode the pin simply shows the inverted proximity state. In interrupt mode the pin rests high and falls as soon as the detector reports a change, in either direction. It then stays low and asserts a hold signal that freezes the detection sequencer. The frozen decision stays readable until the host sends a clear.

On top of the mode logic, a two-bit override code can force the pin high or low, and a run bit puts the block into shutdown. In shutdown the pin goes high, any pending interrupt is dropped and the hold is released. The pin is always actively driven and never floats. Every output is registered, so a change on any input shows up at the pin one clock edge later.

Top module: `prox_pin_ctrl`

## Requirements
- R1: While reset is asserted (rst_n low), and right after it is released, pin_out is 1 and hold_out is 0.
- R2: In level mode (irq_mode=0) with run_en=1 and override code 00 or 01, pin_out after the next rising edge equals the inverse of prox_state sampled at that edge (0 = object present).
- R3: In interrupt mode (irq_mode=1) with run_en=1, pin_out is 1 while no interrupt is pending. A state_chg pulse, whatever the direction of the change, makes hold_out 1 and pin_out 0 (override 00/01) after the next edge.
- R4: Once an interrupt is pending, hold_out stays 1 and pin_out stays 0 on every edge at which irq_clr is 0, regardless of prox_state or further state_chg pulses.
- R5: In interrupt mode, irq_clr=1 with no state_chg at the same edge releases the interrupt: after that edge hold_out is 0 and pin_out is 1 (override 00/01).
- R6: In level mode irq_clr has no effect: pin_out still follows R2 and hold_out stays 0.
- R7: state_chg and irq_clr at the same edge in interrupt mode leave an interrupt pending: hold_out 1 and pin_out 0 after that edge.
- R8: With run_en=1, override code 11 drives pin_out to 1 and code 10 drives it to 0 after the next edge, in either mode. Code 01 behaves as code 00. The override code never changes hold_out.
- R9: run_en=0 drives pin_out to 1 and hold_out to 0 after the next edge. This takes priority over any override code and mode, and it discards any pending interrupt.
- R10: In level mode a state_chg pulse never asserts hold_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| prox_state | input | 1 | Current proximity decision (1 = object present) |
| state_chg | input | 1 | Pulse: the proximity decision has just changed |
| irq_mode | input | 1 | 0 = level mode, 1 = latched interrupt mode |
| ovr_code | input | 2 | Pin override: 00/01 pass, 10 force low, 11 force high |
| run_en | input | 1 | 1 = operating, 0 = shutdown |
| irq_clr | input | 1 | Pulse from the bus interface that clears the interrupt |
| pin_out | output | 1 | Output pin level |
| hold_out | output | 1 | Freezes the detection sequencer while an interrupt is pending |

## Verification
The bound properties assume that every input is synchronous to clk and settles well before each rising edge. They also assume that reset is released away from an edge. The properties compare the outputs one edge after a sampled input, so they rely on the inputs keeping their value through the whole sampling cycle. The stimulus respects this by changing every input only on the falling clock edge and by checking the outputs on the following falling edge. Reset is also asserted and released on a falling edge.

// File: rtl/prox_pin_pkg.sv
package prox_pin_pkg;

  localparam int unsigned OVR_W = 2;

  typedef enum logic [OVR_W-1:0] {
    OVR_PASS   = 2'b00,
    OVR_PASS_B = 2'b01,
    OVR_LOW    = 2'b10,
    OVR_HIGH   = 2'b11
  } ovr_code_e;

  typedef struct packed {
    logic force_en;
    logic force_lvl;
  } ovr_dec_t;

  function automatic ovr_dec_t decode_ovr(input logic [OVR_W-1:0] code);
    ovr_dec_t d;
    d.force_en  = code[OVR_W-1];
    d.force_lvl = code[0];
    return d;
  endfunction

endpackage

// File: rtl/prox_irq_latch.sv
module prox_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic irq_mode,
  input  logic state_chg,
  input  logic irq_clr,
  output logic pend_d,
  output logic pend_q
);

  logic pend_en;

  always_comb begin
    pend_d = pend_q;
    if (!run_en || !irq_mode) begin
      pend_d = 1'b0;
    end else if (state_chg) begin
      pend_d = 1'b1;
    end else if (irq_clr) begin
      pend_d = 1'b0;
    end
  end

  assign pend_en = (pend_d != pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/prox_level_sel.sv
module prox_level_sel
  import prox_pin_pkg::*;
(
  input  logic             irq_mode,
  input  logic             prox_state,
  input  logic             pend_next,
  input  logic [OVR_W-1:0] ovr_code,
  output logic             lvl_next
);

  ovr_dec_t dec;
  logic     mode_lvl;

  assign dec = decode_ovr(ovr_code);

  always_comb begin
    if (irq_mode) begin
      mode_lvl = ~pend_next;
    end else begin
      mode_lvl = ~prox_state;
    end
  end

  always_comb begin
    if (dec.force_en) begin
      lvl_next = dec.force_lvl;
    end else begin
      lvl_next = mode_lvl;
    end
  end

endmodule

// File: rtl/prox_pin_drive.sv
module prox_pin_drive #(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic lvl_next,
  output logic pin_q
);

  logic pin_d;
  logic pin_en;

  always_comb begin
    if (!run_en) begin
      pin_d = IDLE_LVL;
    end else begin
      pin_d = lvl_next;
    end
  end

  assign pin_en = (pin_d != pin_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= IDLE_LVL;
    end else if (pin_en) begin
      pin_q <= pin_d;
    end
  end

endmodule

// File: rtl/prox_pin_ctrl.sv
module prox_pin_ctrl
  import prox_pin_pkg::*;
#(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prox_state,
  input  logic             state_chg,
  input  logic             irq_mode,
  input  logic [OVR_W-1:0] ovr_code,
  input  logic             run_en,
  input  logic             irq_clr,
  output logic             pin_out,
  output logic             hold_out
);

  logic pend_d;
  logic pend_q;
  logic lvl_next;

  prox_irq_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .irq_mode  (irq_mode),
    .state_chg (state_chg),
    .irq_clr   (irq_clr),
    .pend_d    (pend_d),
    .pend_q    (pend_q)
  );

  prox_level_sel u_sel (
    .irq_mode   (irq_mode),
    .prox_state (prox_state),
    .pend_next  (pend_d),
    .ovr_code   (ovr_code),
    .lvl_next   (lvl_next)
  );

  prox_pin_drive #(
    .IDLE_LVL (IDLE_LVL)
  ) u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .lvl_next (lvl_next),
    .pin_q    (pin_out)
  );

  assign hold_out = pend_q;

endmodule

// File: rtl/prox_pin_ctrl_chk.sv
module prox_pin_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       prox_state,
  input logic       state_chg,
  input logic       irq_mode,
  input logic [1:0] ovr_code,
  input logic       run_en,
  input logic       irq_clr,
  input logic       pin_out,
  input logic       hold_out
);

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RESET_STATE: assert (pin_out && !hold_out); // R1
    end
  end

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && !irq_mode && !ovr_code[1] |=> pin_out == !$past(prox_state)); // R2

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && irq_mode && state_chg |=> hold_out); // R3

  AST_IRQ_PIN_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && irq_mode && !ovr_code[1] |=> pin_out == !hold_out); // R3

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    hold_out && run_en && irq_mode && !irq_clr |=> hold_out); // R4

  AST_CLR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && irq_mode && irq_clr && !state_chg |=> !hold_out); // R5

  AST_LEVEL_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mode |=> !hold_out); // R6

  AST_BOTH_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && irq_mode && state_chg && irq_clr |=> hold_out); // R7

  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && ovr_code == 2'b11 |=> pin_out); // R8

  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && ovr_code == 2'b10 |=> !pin_out); // R8

  AST_SHDN_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> pin_out); // R9

  AST_SHDN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !hold_out); // R9

  AST_LEVEL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mode && state_chg |=> !hold_out); // R10

endmodule

bind prox_pin_ctrl prox_pin_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .prox_state (prox_state),
  .state_chg  (state_chg),
  .irq_mode   (irq_mode),
  .ovr_code   (ovr_code),
  .run_en     (run_en),
  .irq_clr    (irq_clr),
  .pin_out    (pin_out),
  .hold_out   (hold_out)
);

// File: tb/sim_prox_pin_ctrl.sv
`timescale 1ns/1ps
module sim_prox_pin_ctrl;

  logic       clk;
  logic       rst_n;
  logic       prox_state;
  logic       state_chg;
  logic       irq_mode;
  logic [1:0] ovr_code;
  logic       run_en;
  logic       irq_clr;
  logic       pin_out;
  logic       hold_out;

  int checks;
  int errors;
  bit done;

  prox_pin_ctrl u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .prox_state (prox_state),
    .state_chg  (state_chg),
    .irq_mode   (irq_mode),
    .ovr_code   (ovr_code),
    .run_en     (run_en),
    .irq_clr    (irq_clr),
    .pin_out    (pin_out),
    .hold_out   (hold_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // vector: [12:9] req, [8] prox, [7] chg, [6] mode, [5:4] ovr, [3] run, [2] clr, [1] exp pin, [0] exp hold
  localparam int NV = 19;
  localparam logic [12:0] VEC [NV] = '{
    {4'd2,  1'b1,1'b0,1'b0,2'b00,1'b1,1'b0, 1'b0,1'b0}, // R2 object -> low
    {4'd2,  1'b0,1'b0,1'b0,2'b00,1'b1,1'b0, 1'b1,1'b0}, // R2 none -> high
    {4'd6,  1'b1,1'b1,1'b0,2'b00,1'b1,1'b1, 1'b0,1'b0}, // R6 clear ignored
    {4'd10, 1'b0,1'b1,1'b0,2'b00,1'b1,1'b0, 1'b1,1'b0}, // R10 no hold in level mode
    {4'd3,  1'b1,1'b0,1'b1,2'b00,1'b1,1'b0, 1'b1,1'b0}, // R3 idle high
    {4'd3,  1'b1,1'b1,1'b1,2'b00,1'b1,1'b0, 1'b0,1'b1}, // R3 0->1 change
    {4'd4,  1'b0,1'b0,1'b1,2'b00,1'b1,1'b0, 1'b0,1'b1}, // R4 held
    {4'd4,  1'b0,1'b1,1'b1,2'b00,1'b1,1'b0, 1'b0,1'b1}, // R4 extra strobe
    {4'd5,  1'b0,1'b0,1'b1,2'b00,1'b1,1'b1, 1'b1,1'b0}, // R5 release
    {4'd3,  1'b0,1'b1,1'b1,2'b00,1'b1,1'b0, 1'b0,1'b1}, // R3 1->0 change
    {4'd7,  1'b0,1'b1,1'b1,2'b00,1'b1,1'b1, 1'b0,1'b1}, // R7 strobe+clear
    {4'd5,  1'b0,1'b0,1'b1,2'b11,1'b1,1'b1, 1'b1,1'b0}, // R5 clear under force high
    {4'd8,  1'b1,1'b1,1'b1,2'b11,1'b1,1'b0, 1'b1,1'b1}, // R8 force high, hold kept
    {4'd8,  1'b1,1'b0,1'b1,2'b10,1'b1,1'b0, 1'b0,1'b1}, // R8 force low
    {4'd8,  1'b1,1'b0,1'b1,2'b01,1'b1,1'b0, 1'b0,1'b1}, // R8 code 01 passes
    {4'd9,  1'b1,1'b0,1'b1,2'b10,1'b0,1'b0, 1'b1,1'b0}, // R9 shutdown beats override
    {4'd9,  1'b1,1'b1,1'b1,2'b00,1'b0,1'b0, 1'b1,1'b0}, // R9 strobe ignored in shutdown
    {4'd8,  1'b1,1'b0,1'b0,2'b01,1'b1,1'b0, 1'b0,1'b0}, // R8 01 in level mode
    {4'd8,  1'b1,1'b0,1'b0,2'b11,1'b1,1'b0, 1'b1,1'b0}  // R8 force high in level mode
  };

  task automatic check_out(input string req, input logic ep, input logic eh);
    checks++;
    if (pin_out !== ep || hold_out !== eh) begin
      errors++;
      $display("FAIL %s: pin=%b hold=%b expected pin=%b hold=%b", req, pin_out, hold_out, ep, eh);
    end
  endtask

  task automatic drive(input logic p, input logic c, input logic m, input logic [1:0] o,
                       input logic r, input logic k);
    prox_state = p; state_chg = c; irq_mode = m; ovr_code = o; run_en = r; irq_clr = k;
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    check_out("R1", 1'b1, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R1", 1'b1, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5:4], VEC[i][3], VEC[i][2]);
      @(negedge clk);
      check_out($sformatf("R%0d vec %0d", VEC[i][12:9], i), VEC[i][1], VEC[i][0]);
    end

    // R4: pending interrupt held over several cycles while prox toggles
    drive(1'b0, 1'b1, 1'b1, 2'b00, 1'b1, 1'b0);
    @(negedge clk);
    for (int j = 0; j < 4; j++) begin
      drive(j[0], 1'b0, 1'b1, 2'b00, 1'b1, 1'b0);
      @(negedge clk);
      check_out("R4 long hold", 1'b0, 1'b1);
    end

    // R9: shutdown discards pending, return to run leaves pin high
    drive(1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0);
    @(negedge clk);
    check_out("R9 pending discarded", 1'b1, 1'b0);

    // R1: asynchronous reset while interrupt pending
    drive(1'b1, 1'b1, 1'b1, 2'b10, 1'b1, 1'b0);
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b1, 2'b10, 1'b1, 1'b0);
    #1 rst_n = 1'b0;
    #1 check_out("R1 async reset", 1'b1, 1'b0);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b1, 2'b00, 1'b1, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R1 after release", 1'b1, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule